// File: doc/BRIEF.md
# Scan Test Vector Sequencer

This block drives a full-scan circuit under test through a stream of combinational test vectors. Each vector carries a per-chain state pattern, the primary-input bits to apply, the expected captured state and the expected primary-output bits. It also carries one compare mask for the state bits and one for the output bits. Vectors arrive through a valid/ready port into a one-entry holding slot. The sequencer shifts the pattern into every chain in scan mode. It then spends one normal-mode clock applying the primary inputs and capturing the next state. While the next vector shifts in, it checks the captured response as it shifts out.

Several chains of unequal length share one mode output. Shorter chains receive zero filler first, so that every chain completes its load on the same clock. A run lasts as long as vectors keep arriving in time. A capture with no vector waiting is followed by a final unload of zeros. After that the run closes with a done flag and a saturating count of mismatching bits. One run of n vectors takes n·(L+1)+L clocks, where L is the longest chain.

Top module: `scanvec_seq`

## Requirements
- R1: After reset, scan_mode, done, mismatch_count, cut_pi and scan_in are all 0, and vec_ready is 1.
- R2: vec_ready is high exactly while the holding slot is empty. A vector is accepted on a clock where vec_valid and vec_ready are both high. vec_ready stays low until the sequencer takes that vector.
- R3: A run starts when a vector is waiting while idle. Each vector gets L shift clocks with scan_mode=1, then one capture clock with scan_mode=0. During the capture clock cut_pi equals the vector's PI bits. In every other clock cut_pi is 0.
- R4: Pattern bit k of chain c sits at field index c·L+k and ends up in flip-flop k of that chain, where flip-flop 0 is the one next to scan-in. The sequencer drives the highest index first. Indices at or above the chain's length are leading filler and are driven as 0.
- R5: A vector waiting at a capture clock starts loading on the very next clock. If none is waiting, an L-clock unload with scan_in=0 follows. A run of n vectors spans exactly n·(L+1)+L clocks.
- R6: In shift clock t after a capture, scan_out of chain c (length Lc) is compared with expected bit Lc−1−t when t<Lc and that mask bit is 1. Mask 1 means compare. Nothing is compared during a run's first load, and filler positions are never compared.
- R7: During each capture clock, every cut_po bit whose mask bit is 1 is compared with the expected PO bit.
- R8: mismatch_count adds the number of mismatching compared bits in each clock. It saturates at 2^CNT_W−1 and clears when a run starts.
- R9: done rises on the clock after the last unload clock, with scan_mode at 0. It stays high until the next run starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_valid | input | 1 | Vector offered |
| vec_ready | output | 1 | Holding slot empty |
| vec_pattern | input | NUM_CHAINS·L | State pattern to shift in |
| vec_pi | input | PI_W | Primary inputs for the capture clock |
| vec_exp_state | input | NUM_CHAINS·L | Expected captured state |
| vec_state_mask | input | NUM_CHAINS·L | Compare enable per state bit |
| vec_exp_po | input | PO_W | Expected primary outputs |
| vec_po_mask | input | PO_W | Compare enable per output bit |
| scan_mode | output | 1 | 1 = shift, 0 = normal/capture |
| scan_in | output | NUM_CHAINS | Serial data into each chain |
| scan_out | input | NUM_CHAINS | Serial data from each chain |
| cut_pi | output | PI_W | Primary inputs to the circuit under test |
| cut_po | input | PO_W | Primary outputs from the circuit under test |
| mismatch_count | output | CNT_W | Saturating mismatch total of the run |
| done | output | 1 | Run complete |

## Verification
The bench builds the block with two chains of lengths 4 and 3, so L is 4 and one chain needs a leading filler bit. It uses two PI bits, two PO bits and a 4-bit counter. A small circuit under test inside the bench has known next-state and output functions. With it the bench can predict every captured state and every shifted-out bit arithmetically. It can also check the shift ordering, the filler slot and the first-load blanking. The narrow counter lets a five-vector run of fully flipped expectations (45 mismatches) reach saturation within a few dozen clocks.

// File: rtl/scanvec_pkg.sv
package scanvec_pkg;

  localparam int unsigned LENS_BITS = 256;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_LOAD,
    SQ_CAPTURE,
    SQ_UNLOAD
  } seq_state_e;

  // length of chain c from a packed list of 8-bit lengths
  function automatic int unsigned lens_get(input logic [LENS_BITS-1:0] lens,
                                           input int unsigned c);
    return 32'(lens[c*8 +: 8]);
  endfunction

  function automatic int unsigned lens_max(input logic [LENS_BITS-1:0] lens,
                                           input int unsigned n);
    int unsigned m;
    m = 1;
    for (int unsigned i = 0; i < n; i++) begin
      if (lens_get(lens, i) > m) m = lens_get(lens, i);
    end
    return m;
  endfunction

  // clocks from first shift to last unload shift for n vectors
  function automatic int unsigned run_clocks(input int unsigned n_vec,
                                             input int unsigned ml);
    return n_vec * (ml + 1) + ml;
  endfunction

  function automatic int unsigned sat_add(input int unsigned a,
                                          input int unsigned b,
                                          input int unsigned lim);
    return (a + b > lim) ? lim : a + b;
  endfunction

endpackage

// File: rtl/scanvec_slot.sv
module scanvec_slot #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  input  logic         take,
  output logic         ready,
  output logic         full,
  output logic [W-1:0] data
);

  assign ready = !full;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else if (in_valid && !full) begin
      full <= 1'b1;
      data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  // R2: a held vector is neither dropped nor overwritten until taken
  assert_slot_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take) |=> (full && $stable(data)));

  // R2: the sequencer only pulls from a filled slot
  assert_take_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> full);

endmodule

// File: rtl/scanvec_ctrl.sv
module scanvec_ctrl
  import scanvec_pkg::*;
#(
  parameter int unsigned ML = 4,
  localparam int unsigned TW = (ML > 1) ? $clog2(ML) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_full,
  output seq_state_e    st,
  output logic [TW-1:0] t,
  output logic          take,
  output logic          shift,
  output logic          capture,
  output logic          start_run,
  output logic          finish,
  output logic          have_prev
);

  localparam logic [TW-1:0] LAST = TW'(ML - 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= SQ_IDLE;
      t         <= '0;
      have_prev <= 1'b0;
    end else begin
      unique case (st)
        SQ_IDLE: begin
          t <= '0;
          if (slot_full) begin
            st        <= SQ_LOAD;
            have_prev <= 1'b0;
          end
        end
        SQ_LOAD: begin
          if (t == LAST) begin
            st <= SQ_CAPTURE;
            t  <= '0;
          end else begin
            t <= t + 1'b1;
          end
        end
        SQ_CAPTURE: begin
          have_prev <= 1'b1;
          t         <= '0;
          st        <= slot_full ? SQ_LOAD : SQ_UNLOAD;
        end
        SQ_UNLOAD: begin
          if (t == LAST) begin
            st <= SQ_IDLE;
            t  <= '0;
          end else begin
            t <= t + 1'b1;
          end
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end

  assign shift     = (st == SQ_LOAD) || (st == SQ_UNLOAD);
  assign capture   = (st == SQ_CAPTURE);
  assign start_run = (st == SQ_IDLE) && slot_full;
  assign take      = start_run || (capture && slot_full);
  assign finish    = (st == SQ_UNLOAD) && (t == LAST);

  // R3: a full load is always followed by one capture clock
  assert_load_to_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == SQ_LOAD && t == LAST) |=> (st == SQ_CAPTURE));

  // R5: a capture without a waiting vector leads into the unload
  assert_empty_to_unload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !slot_full) |=> (st == SQ_UNLOAD && t == '0));

  // R5: a waiting vector starts loading right after the capture
  assert_overlap_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && slot_full) |=> (st == SQ_LOAD && t == '0 && have_prev));

  // R6: the first load of a run carries no previous response
  assert_first_load_blank_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_run |=> !have_prev);

endmodule

// File: rtl/scanvec_tally.sv
module scanvec_tally
  import scanvec_pkg::*;
#(
  parameter int unsigned NB    = 4,
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [NB-1:0]    miss,
  output logic [CNT_W-1:0] count
);

  localparam int unsigned LIM = (1 << CNT_W) - 1;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      count <= '0;
    end else begin
      count <= CNT_W'(sat_add(32'(count), 32'($countones(miss)), LIM));
    end
  end

  // R8: the total holds at its ceiling
  assert_sat_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && count == CNT_W'(LIM)) |=> (count == CNT_W'(LIM)));

  // R8: without a clear the total never decreases (no wrap)
  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !clear |=> (count >= $past(count)));

  // R8: clearing empties the total
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (count == '0));

endmodule

// File: rtl/scanvec_seq.sv
module scanvec_seq
  import scanvec_pkg::*;
#(
  parameter int unsigned NUM_CHAINS = 2,
  parameter logic [NUM_CHAINS*8-1:0] CHAIN_LENS = 16'h0304,
  parameter int unsigned PI_W  = 2,
  parameter int unsigned PO_W  = 2,
  parameter int unsigned CNT_W = 4,
  localparam int unsigned ML = lens_max(LENS_BITS'(CHAIN_LENS), NUM_CHAINS),
  localparam int unsigned SB = NUM_CHAINS * ML
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  vec_valid,
  output logic                  vec_ready,
  input  logic [SB-1:0]         vec_pattern,
  input  logic [PI_W-1:0]       vec_pi,
  input  logic [SB-1:0]         vec_exp_state,
  input  logic [SB-1:0]         vec_state_mask,
  input  logic [PO_W-1:0]       vec_exp_po,
  input  logic [PO_W-1:0]       vec_po_mask,
  output logic                  scan_mode,
  output logic [NUM_CHAINS-1:0] scan_in,
  input  logic [NUM_CHAINS-1:0] scan_out,
  output logic [PI_W-1:0]       cut_pi,
  input  logic [PO_W-1:0]       cut_po,
  output logic [CNT_W-1:0]      mismatch_count,
  output logic                  done
);

  localparam int unsigned TW = (ML > 1) ? $clog2(ML) : 1;
  localparam int unsigned VW = 3 * SB + PI_W + 2 * PO_W;
  localparam int unsigned NB = NUM_CHAINS + PO_W;

  // ---------------- holding slot ----------------
  logic          slot_full;
  logic [VW-1:0] slot_data;
  logic          take;

  scanvec_slot #(.W(VW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (vec_valid),
    .in_data  ({vec_pattern, vec_exp_state, vec_state_mask,
                vec_pi, vec_exp_po, vec_po_mask}),
    .take     (take),
    .ready    (vec_ready),
    .full     (slot_full),
    .data     (slot_data)
  );

  // ---------------- sequencing ----------------
  seq_state_e    st;
  logic [TW-1:0] t;
  logic          shift, capture, start_run, finish, have_prev;

  scanvec_ctrl #(.ML(ML)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_full (slot_full),
    .st        (st),
    .t         (t),
    .take      (take),
    .shift     (shift),
    .capture   (capture),
    .start_run (start_run),
    .finish    (finish),
    .have_prev (have_prev)
  );

  // ---------------- vector registers ----------------
  logic [SB-1:0]   cur_pat, cur_exp, cur_mask, prev_exp, prev_mask;
  logic [PI_W-1:0] cur_pi;
  logic [PO_W-1:0] cur_exp_po, cur_po_mask;
  logic            done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur_pat     <= '0;
      cur_exp     <= '0;
      cur_mask    <= '0;
      cur_pi      <= '0;
      cur_exp_po  <= '0;
      cur_po_mask <= '0;
      prev_exp    <= '0;
      prev_mask   <= '0;
      done_q      <= 1'b0;
    end else begin
      if (capture) begin
        prev_exp  <= cur_exp;
        prev_mask <= cur_mask;
      end
      if (take) begin
        {cur_pat, cur_exp, cur_mask, cur_pi, cur_exp_po, cur_po_mask} <= slot_data;
      end
      if (start_run)   done_q <= 1'b0;
      else if (finish) done_q <= 1'b1;
    end
  end

  assign scan_mode = shift;
  assign cut_pi    = capture ? cur_pi : '0;
  assign done      = done_q;

  // ---------------- per-chain data paths ----------------
  logic [NUM_CHAINS-1:0] chain_miss;
  logic [PO_W-1:0]       po_miss;

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    localparam int unsigned CL = lens_get(LENS_BITS'(CHAIN_LENS), c);
    logic si_bit, miss_bit;

    always_comb begin
      int unsigned pos;
      pos    = ML - 1 - 32'(t);
      si_bit = 1'b0;
      if (st == SQ_LOAD && pos < CL) si_bit = cur_pat[c*ML + pos];
    end

    always_comb begin
      int unsigned k;
      miss_bit = 1'b0;
      k        = 0;
      if (shift && have_prev && 32'(t) < CL) begin
        k        = CL - 1 - 32'(t);
        miss_bit = prev_mask[c*ML + k] & (scan_out[c] ^ prev_exp[c*ML + k]);
      end
    end

    assign scan_in[c]    = si_bit;
    assign chain_miss[c] = miss_bit;
  end

  assign po_miss = capture ? (cur_po_mask & (cut_po ^ cur_exp_po)) : '0;

  // ---------------- mismatch total ----------------
  scanvec_tally #(.NB(NB), .CNT_W(CNT_W)) u_tally (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (start_run),
    .miss  ({po_miss, chain_miss}),
    .count (mismatch_count)
  );

  // R3: the capture clock is immediately followed by shifting
  assert_capture_then_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> scan_mode);

  // R9: done follows the final unload with the circuit in normal mode
  assert_done_after_unload_R9: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> (done && !scan_mode));

  // R9: a starting run drops done and begins shifting
  assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    start_run |=> (!done && scan_mode));

  // R6: no chain mismatch is ever counted while idle or capturing
  assert_compare_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_mode |-> (chain_miss == '0));

endmodule

// File: tb/scanvec_seq_bench.sv
module scanvec_seq_bench;

  localparam int unsigned ML = 4;
  localparam int unsigned SB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          vec_valid = 1'b0;
  logic          vec_ready;
  logic [SB-1:0] vec_pattern = '0, vec_exp_state = '0, vec_state_mask = '0;
  logic [1:0]    vec_pi = '0, vec_exp_po = '0, vec_po_mask = '0;
  logic          scan_mode, done;
  logic [1:0]    scan_in, scan_out, cut_pi, cut_po;
  logic [3:0]    mismatch_count;

  scanvec_seq u_scanvec_seq (
    .clk(clk), .rst_n(rst_n), .vec_valid(vec_valid), .vec_ready(vec_ready),
    .vec_pattern(vec_pattern), .vec_pi(vec_pi), .vec_exp_state(vec_exp_state),
    .vec_state_mask(vec_state_mask), .vec_exp_po(vec_exp_po), .vec_po_mask(vec_po_mask),
    .scan_mode(scan_mode), .scan_in(scan_in), .scan_out(scan_out), .cut_pi(cut_pi),
    .cut_po(cut_po), .mismatch_count(mismatch_count), .done(done)
  );

  // ---------------- circuit under test model ----------------
  logic [3:0] q0;
  logic [2:0] q1;

  function automatic logic [6:0] cut_next(input logic [3:0] s0, input logic [2:0] s1,
                                          input logic [1:0] pi);
    logic [3:0] n0;
    logic [2:0] n1;
    n0 = s0 + {s1, pi[0]};
    n1 = s1 ^ {pi, s0[3]};
    return {n1, n0};
  endfunction

  function automatic logic [1:0] cut_outf(input logic [3:0] s0, input logic [2:0] s1,
                                          input logic [1:0] pi);
    return {(^s0) ^ pi[1], (^s1) ^ pi[0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      q0 <= 4'hF;
      q1 <= 3'h5;
    end else if (scan_mode) begin
      q0 <= {q0[2:0], scan_in[0]};
      q1 <= {q1[1:0], scan_in[1]};
    end else begin
      {q1, q0} <= cut_next(q0, q1, cut_pi);
    end
  end
  assign scan_out = {q1[2], q0[3]};
  assign cut_po   = cut_outf(q0, q1, cut_pi);

  // ---------------- check bookkeeping ----------------
  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- vector store ----------------
  logic [7:0] v_pat[16], v_exp[16], v_mask[16];
  logic [1:0] v_pi[16], v_epo[16], v_pmask[16];
  int         exp_total;

  // mode 0: correct expectations; 1: random flips/masks; 2: every bit flipped, all masked
  task automatic build(input int n, input int mode);
    int raw;
    raw = 0;
    for (int v = 0; v < n; v++) begin
      logic [6:0] ns;
      logic [7:0] err;
      logic [1:0] perr, tpo;
      v_pat[v] = 8'($urandom);
      v_pi[v]  = 2'($urandom);
      ns  = cut_next(v_pat[v][3:0], v_pat[v][6:4], v_pi[v]);
      tpo = cut_outf(v_pat[v][3:0], v_pat[v][6:4], v_pi[v]);
      case (mode)
        0: begin err = 8'h00; perr = 2'b00; v_mask[v] = 8'hFF; v_pmask[v] = 2'b11; end
        1: begin err = 8'($urandom); perr = 2'($urandom);
                 v_mask[v] = 8'($urandom); v_pmask[v] = 2'($urandom); end
        default: begin err = 8'hFF; perr = 2'b11; v_mask[v] = 8'hFF; v_pmask[v] = 2'b11; end
      endcase
      v_exp[v] = {1'b0, ns} ^ err;
      v_epo[v] = tpo ^ perr;
      // bit 7 is chain 1 filler and is never compared
      raw += $countones(err & v_mask[v] & 8'h7F) + $countones(perr & v_pmask[v]);
    end
    exp_total = (raw > 15) ? 15 : raw;
  endtask

  task automatic feeder(input int n);
    for (int v = 0; v < n; v++) begin
      @(negedge clk);
      vec_pattern = v_pat[v]; vec_pi = v_pi[v]; vec_exp_state = v_exp[v];
      vec_state_mask = v_mask[v]; vec_exp_po = v_epo[v]; vec_po_mask = v_pmask[v];
      vec_valid = 1'b1;
      while (!vec_ready) @(negedge clk);
      @(negedge clk);
      vec_valid = 1'b0;
      chk(vec_ready == 1'b0, "R2 ready low while slot held", int'(vec_ready), 0);
    end
  endtask

  task automatic monitor(input int n);
    bit started;
    int cyc, sc, capn;
    started = 0; cyc = 0; sc = 0; capn = 0;
    forever begin
      @(negedge clk);
      if (!started) begin
        if (!scan_mode) continue;
        started = 1;
        chk(done == 1'b0, "R9 done cleared at run start", int'(done), 0);
        chk(mismatch_count == 0, "R8 count cleared at run start", int'(mismatch_count), 0);
      end
      if (done) break;
      cyc++;
      if (scan_mode) begin
        if (sc == 0)
          chk(scan_in[1] == 1'b0, "R4 filler bit zero", int'(scan_in[1]), 0);
        if (capn == n)
          chk(scan_in == 2'b00, "R5 unload drives zeros", int'(scan_in), 0);
        chk(cut_pi == 2'b00, "R3 pi idle outside capture", int'(cut_pi), 0);
        sc++;
      end else begin
        chk(sc == ML, "R3 shift clocks per vector", sc, ML);
        chk(cut_pi == v_pi[capn], "R3 pi at capture", int'(cut_pi), int'(v_pi[capn]));
        chk({q1, q0} == v_pat[capn][6:0], "R4 loaded state order",
            int'({q1, q0}), int'(v_pat[capn][6:0]));
        capn++;
        sc = 0;
      end
    end
    chk(cyc == n * (ML + 1) + ML, "R5 run length", cyc, n * (ML + 1) + ML);
    chk(capn == n, "R3 capture count", capn, n);
    chk(sc == ML, "R5 unload length", sc, ML);
    chk(scan_mode == 1'b0, "R9 normal mode when done", int'(scan_mode), 0);
    chk(mismatch_count == 4'(exp_total), "R6 R7 R8 mismatch total",
        int'(mismatch_count), exp_total);
  endtask

  task automatic do_run(input int n, input int mode);
    build(n, mode);
    fork
      feeder(n);
      monitor(n);
    join
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(scan_mode == 1'b0, "R1 scan_mode", int'(scan_mode), 0);
    chk(done == 1'b0, "R1 done", int'(done), 0);
    chk(mismatch_count == 0, "R1 count", int'(mismatch_count), 0);
    chk(vec_ready == 1'b1, "R1 ready", int'(vec_ready), 1);
    chk(cut_pi == 2'b00 && scan_in == 2'b00, "R1 drive idle", int'({cut_pi, scan_in}), 0);

    do_run(3, 0);            // clean run, first-load blanking (R6)
    do_run(1, 2);            // single vector, all bits wrong: 7 state + 2 PO
    for (int r = 0; r < 6; r++) do_run(4, 1);   // random flips and masks
    do_run(5, 2);            // 45 mismatches saturate at 15 (R8)
    do_run(2, 0);            // clears after saturation

    repeat (3) @(negedge clk);
    chk(done == 1'b1 && scan_mode == 1'b0, "R9 done held in idle", int'(done), 1);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule